// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Engine

This block is the read side of a small two-wire serial EEPROM acting as a bus target. It oversamples the SCL and SDA lines with the local clock and detects START and STOP. It takes in the 8-bit select byte and answers a matching read request. It then streams bytes from its internal byte array, most significant bit first. After each byte the address pointer steps forward, and it wraps from the last location back to zero. Streaming carries on while the controller acknowledges each byte. A NACK followed by STOP ends the read. A write-direction select followed by one word-address byte loads the pointer. A repeated START with a read select then begins a sequential read at that address. Stored data bytes in write cycles are out of scope: bytes after the word address are not acknowledged. The array is filled through a plain programming port.

The array holds 128, 256 or 512 bytes, set by `MEM_BYTES`. In the 512-byte build, select bit 1 is a page bit. It supplies address bit 8 and is not compared against a strap. A running increment carries from 255 into 256. SDA is never driven high: `sda_oe` asks the pad to pull the line low.

The control state machine has these states. IDLE is the quiet state after reset or STOP. RX_SEL shifts in the select byte. ACK_SEL pulls SDA low for the ninth clock. RX_WADDR shifts in the word address. ACK_WADDR acknowledges it. SEND drives data bits. MACK samples the controller's acknowledge. IGNORE keeps SDA released until the next START or STOP.

Its transitions are as follows. START moves any state to RX_SEL, and STOP moves any state to IDLE. RX_SEL goes to ACK_SEL on a match, or to IGNORE on a mismatch. ACK_SEL goes to SEND for a read, or to RX_WADDR for a write. RX_WADDR goes to ACK_WADDR, then ACK_WADDR goes to IGNORE. SEND goes to MACK after D0. MACK goes to SEND on ACK, or to IGNORE on NACK.

Top module: `eerd_seq_reader`

## Requirements
- R1: A select byte with 1010 in bits 7:4, strap match in bits 3:1 (bit 0 = 1 read, 0 write) is acknowledged by `sda_oe` high during the ninth SCL clock.
- R2: A select byte with a wrong device code or strap gets no acknowledge, and SDA stays released for the rest of that transfer.
- R3: Data bits leave D7 first, and a read select starts at the pointer exactly as the previous access left it.
- R4: When the controller acknowledges after D0, the next byte comes from the pointer plus one.
- R5: After a NACK the block releases SDA and sends nothing more until a START; the pointer has already stepped past the NACKed byte.
- R6: The pointer wraps from the last array location to address 0 during a sequential read.
- R7: A write select followed by a word-address byte gets an acknowledge for both bytes and loads the pointer. A repeated START and read select then reads from there.
- R8: In the 512-byte build only select bits 3:2 are compared with straps 2:1; select bit 1 sets address bit 8 on every select.
- R9: In the 512-byte build the increment carries from address 255 to 256 within one sequential read.
- R10: A START at any point aborts the current transfer and restarts select-byte reception.
- R11: `sda_oe` only rises while SCL is low.
- R12: After reset `sda_oe` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap | input | 3 | Address strap inputs compared with select bits 3:1 |
| fill_en | input | 1 | Programming-port write strobe |
| fill_addr | input | log2(MEM_BYTES) | Programming-port address |
| fill_data | input | 8 | Programming-port data |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The bench drives a 256-byte and a 512-byte instance on one shared open-drain bus and goes after pointer boundaries. A read straddling 0xFF to 0x00 catches a pointer that saturates or misses the wrap. The 512-byte read crossing 0x0FF to 0x100 catches an increment that does not carry into the page bit. A NACK followed by extra clocks shows whether the block wrongly keeps driving data. Mismatched selects, and a START cut into a half-received select byte, show whether a design acknowledges foreign traffic or loses bit alignment. Current reads after each case prove the pointer was left where it belongs.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_SEL,
        ST_ACK_SEL,
        ST_RX_WADDR,
        ST_ACK_WADDR,
        ST_SEND,
        ST_MACK,
        ST_IGNORE
    } rd_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eerd_line_mon.sv
module eerd_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_lvl  = scl_sh[SYNC_STAGES-1];
    assign sda_lvl  = sda_sh[SYNC_STAGES-1];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eerd_sel_match.sv
module eerd_sel_match
    import eerd_pkg::*;
#(
    parameter bit PAGED = 1'b0
) (
    input  logic [7:0] sel_byte,
    input  logic [2:0] strap,
    output logic       hit,
    output logic       is_read,
    output logic       page_bit
);

    logic code_ok;
    assign code_ok = (sel_byte[7:4] == DEV_CODE);
    assign is_read = sel_byte[0];

    generate
        if (PAGED) begin : g_paged
            logic unused_strap0;
            assign unused_strap0 = strap[0];
            assign hit      = code_ok && (sel_byte[3:2] == strap[2:1]);
            assign page_bit = sel_byte[1];
        end else begin : g_flat
            assign hit      = code_ok && (sel_byte[3:1] == strap);
            assign page_bit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/eerd_store.sv
module eerd_store #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [7:0]    fill_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            cells[fill_addr] <= fill_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eerd_seq_reader.sv
module eerd_seq_reader
    import eerd_pkg::*;
#(
    parameter int MEM_BYTES   = 256,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    strap,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [7:0]    fill_data,
    output logic          sda_oe
);

    localparam bit PAGED = (MEM_BYTES > 256);

    rd_state_e     state, state_n;
    logic [7:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic [2:0]    bit_cnt;
    logic          byte_done;
    logic          page_q;
    logic          m_nack;
    logic [AW-1:0] ptr;
    logic [AW-1:0] waddr_val;
    logic [7:0]    rd_data;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic sel_hit, sel_rd, sel_page;

    eerd_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eerd_sel_match #(.PAGED(PAGED)) u_sel (
        .sel_byte (rx_sh),
        .strap    (strap),
        .hit      (sel_hit),
        .is_read  (sel_rd),
        .page_bit (sel_page)
    );

    eerd_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
        .clk       (clk),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .rd_addr   (ptr),
        .rd_data   (rd_data)
    );

    // Word-address byte joined with the page bit latched from the select.
    assign waddr_val = AW'({page_q, rx_sh});

    // Next-state decision
    always_comb begin
        state_n = state;
        if (stop_ev) begin
            state_n = ST_IDLE;
        end else if (start_ev) begin
            state_n = ST_RX_SEL;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_RX_SEL: begin
                    if (scl_fall && byte_done)
                        state_n = sel_hit ? ST_ACK_SEL : ST_IGNORE;
                end
                ST_ACK_SEL: begin
                    if (scl_fall)
                        state_n = sel_rd ? ST_SEND : ST_RX_WADDR;
                end
                ST_RX_WADDR: begin
                    if (scl_fall && byte_done)
                        state_n = ST_ACK_WADDR;
                end
                ST_ACK_WADDR: begin
                    if (scl_fall)
                        state_n = ST_IGNORE;
                end
                ST_SEND: begin
                    if (scl_fall && (bit_cnt == 3'd7))
                        state_n = ST_MACK;
                end
                ST_MACK: begin
                    if (scl_fall)
                        state_n = m_nack ? ST_IGNORE : ST_SEND;
                end
                ST_IGNORE: state_n = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Shift registers, bit counter and address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            tx_sh     <= '1;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            page_q    <= 1'b0;
            m_nack    <= 1'b1;
            ptr       <= '0;
        end else if (start_ev || stop_ev) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            unique case (state)
                ST_RX_SEL, ST_RX_WADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7)
                            byte_done <= 1'b1;
                    end else if (scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (state == ST_RX_WADDR) begin
                            ptr <= waddr_val;
                        end else if (sel_hit) begin
                            page_q <= sel_page;
                            if (PAGED && sel_rd)
                                ptr[AW-1] <= sel_page;
                        end
                    end
                end
                ST_ACK_SEL: begin
                    if (scl_fall && sel_rd) begin
                        tx_sh   <= rd_data;
                        bit_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                        end else begin
                            tx_sh   <= {tx_sh[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise)
                        m_nack <= sda_lvl;
                    else if (scl_fall && !m_nack)
                        tx_sh <= rd_data;
                end
                ST_IDLE, ST_ACK_WADDR, ST_IGNORE: begin
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ACK_SEL, ST_ACK_WADDR: sda_oe = 1'b1;
            ST_SEND:                  sda_oe = ~tx_sh[7];
            default:                  sda_oe = 1'b0;
        endcase
    end

    // R1: a matching select is acknowledged right after the eighth bit
    p_sel_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX_SEL && scl_fall && byte_done && sel_hit) |=> sda_oe);

    // R2: nothing is driven while ignoring the transfer
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R4: pointer steps by one after each sent byte
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && scl_fall && bit_cnt == 3'd7)
        |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R5: a NACK releases the line and ends the read
    p_nack_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && scl_fall && m_nack)
        |=> (state == ST_IGNORE && !sda_oe));

    // R10: START restarts select reception from bit zero
    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_RX_SEL && bit_cnt == 3'd0 && !byte_done));

    // R11: the pull-down only engages while SCL is low
    p_oe_rise_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

endmodule

// File: tb/eerd_seq_reader_test.sv
module eerd_seq_reader_test;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       fill_en = 1'b0;
    logic [8:0] fill_addr = '0;
    logic [7:0] fill_data = '0;
    logic       fill_a = 1'b0;
    logic       fill_b = 1'b0;
    logic       oe_a, oe_b, sda_line;
    int         tests = 0;
    int         fails = 0;
    int         r11_viol = 0;
    logic       oe_a_prev = 1'b0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~oe_a & ~oe_b;

    eerd_seq_reader #(.MEM_BYTES(256)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap(3'b001), .fill_en(fill_a), .fill_addr(fill_addr[7:0]),
        .fill_data(fill_data), .sda_oe(oe_a)
    );

    eerd_seq_reader #(.MEM_BYTES(512)) uut512 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap(3'b110), .fill_en(fill_b), .fill_addr(fill_addr),
        .fill_data(fill_data), .sda_oe(oe_b)
    );

    function automatic logic [7:0] pat_a(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] pat_b(int a);
        return 8'((a * 53 + (a >> 8) * 100 + 7) & 255);
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; half();
        scl = 1'b1;   half();
        m_sda = 1'b0; half();
        scl = 1'b0;   half();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; half();
        scl = 1'b1;   half();
        m_sda = 1'b1; half();
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; half();
            scl = 1'b1;   half();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(logic [7:0] b, output logic ackd);
        send_bits(b, 8);
        m_sda = 1'b1; half();
        scl = 1'b1;   half();
        ackd = ~sda_line;
        scl = 1'b0;
    endtask

    task automatic recv_byte(logic ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            half();
            scl = 1'b1; half();
            b = {b[6:0], sda_line};
            scl = 1'b0;
        end
        m_sda = ~ack; half();
        scl = 1'b1;   half();
        scl = 1'b0;
        m_sda = 1'b1;
    endtask

    // R11 watcher at the pins
    always @(posedge clk) begin
        oe_a_prev <= oe_a;
        if (rst_n && oe_a && !oe_a_prev && scl) r11_viol <= r11_viol + 1;
    end

    task automatic t_reset();
        logic ak; logic [7:0] d;
        check("R12 oe after reset", oe_a | oe_b, 0);
        i2c_start();
        send_byte(8'hA3, ak);
        check("R1 read select ack", ak, 1);
        recv_byte(1'b0, d);
        check("R12 pointer starts at 0", d, pat_a(0));
        i2c_stop();
    endtask

    task automatic t_random_wrap();
        logic ak; logic [7:0] d;
        i2c_start();
        send_byte(8'hA2, ak);
        check("R7 write select ack", ak, 1);
        send_byte(8'hFE, ak);
        check("R7 word address ack", ak, 1);
        i2c_start();
        send_byte(8'hA3, ak);
        check("R1 repeated start select ack", ak, 1);
        recv_byte(1'b1, d);
        check("R7 R3 first byte at word address", d, pat_a(254));
        recv_byte(1'b1, d);
        check("R4 next byte", d, pat_a(255));
        recv_byte(1'b1, d);
        check("R6 wrap to 0", d, pat_a(0));
        recv_byte(1'b0, d);
        check("R4 after wrap", d, pat_a(1));
        i2c_stop();
    endtask

    task automatic t_current();
        logic ak; logic [7:0] d;
        i2c_start();
        send_byte(8'hA3, ak);
        recv_byte(1'b0, d);
        check("R3 current read continues", d, pat_a(2));
        i2c_stop();
    endtask

    task automatic t_nack_release();
        logic ak; logic [7:0] d;
        i2c_start();
        send_byte(8'hA3, ak);
        recv_byte(1'b0, d);
        check("R5 byte before NACK", d, pat_a(3));
        recv_byte(1'b0, d);
        check("R5 released after NACK", d, 8'hFF);
        i2c_stop();
        i2c_start();
        send_byte(8'hA3, ak);
        recv_byte(1'b0, d);
        check("R5 pointer stepped past NACKed byte", d, pat_a(4));
        i2c_stop();
    endtask

    task automatic t_mismatch();
        logic ak; logic [7:0] d;
        i2c_start();
        send_byte(8'hA7, ak);
        check("R2 strap mismatch no ack", ak, 0);
        recv_byte(1'b0, d);
        check("R2 line released", d, 8'hFF);
        i2c_stop();
        i2c_start();
        send_byte(8'hB3, ak);
        check("R2 device code mismatch no ack", ak, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'hA3, ak);
        recv_byte(1'b0, d);
        check("R2 pointer untouched", d, pat_a(5));
        i2c_stop();
    endtask

    task automatic t_abort();
        logic ak; logic [7:0] d;
        i2c_start();
        send_bits(8'hA3, 4);
        i2c_start();
        send_byte(8'hA3, ak);
        check("R10 select after abort acked", ak, 1);
        recv_byte(1'b0, d);
        check("R10 data after abort", d, pat_a(6));
        i2c_stop();
    endtask

    task automatic t_paged();
        logic ak; logic [7:0] d;
        i2c_start();
        send_byte(8'hAC, ak);
        check("R8 512 write select ack", ak, 1);
        send_byte(8'hFF, ak);
        i2c_start();
        send_byte(8'hAD, ak);
        check("R8 512 read select ack", ak, 1);
        recv_byte(1'b1, d);
        check("R8 page0 addr 0xFF", d, pat_b(255));
        recv_byte(1'b0, d);
        check("R9 carry to 0x100", d, pat_b(256));
        i2c_stop();
        i2c_start();
        send_byte(8'hAF, ak);
        recv_byte(1'b0, d);
        check("R8 page bit 1 current read", d, pat_b(257));
        i2c_stop();
        i2c_start();
        send_byte(8'hAD, ak);
        recv_byte(1'b0, d);
        check("R8 page bit 0 overrides carry", d, pat_b(2));
        i2c_stop();
        i2c_start();
        send_byte(8'hAE, ak);
        send_byte(8'hFF, ak);
        i2c_start();
        send_byte(8'hAF, ak);
        recv_byte(1'b1, d);
        check("R8 page1 addr 0x1FF", d, pat_b(511));
        recv_byte(1'b0, d);
        check("R6 512 wrap to 0", d, pat_b(0));
        i2c_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            fill_addr = 9'(a);
            fill_data = pat_b(a);
            fill_b    = 1'b1;
            fill_a    = 1'b0;
            @(negedge clk);
            fill_data = pat_a(a & 255);
            fill_b    = 1'b0;
            fill_a    = (a < 256);
        end
        @(negedge clk);
        fill_a = 1'b0;
        fill_b = 1'b0;
        half();
        t_reset();
        t_random_wrap();
        t_current();
        t_nack_release();
        t_mismatch();
        t_abort();
        t_paged();
        check("R11 pull-down rises only with SCL low", r11_viol, 0);
        finish_run();
    end

endmodule